// File: doc/BRIEF.md
# Message-Buffer Interrupt Vector Generator

This block gathers completion events from sixteen message buffers and three status sources (bus-off, error, wake-up). It keeps a sticky flag per source, a mask per source, and a configuration register. The configuration register holds one request level and a vector base. When any flagged source is also enabled, the block raises the single request line that matches the programmed level on a seven-line request bus.

When the processor acknowledges that level and the block wins arbitration, the block returns an 8-bit vector one cycle later. The upper three bits of the vector are the programmed base. The lower five bits are the code of the lowest-numbered pending source.

Software clears a flag in two steps. It first reads the flag register while the bit is set, then writes that bit back as zero. If a new event arrives for that bit at any point in between, the bit stays set.

Top module: `msg_irq_vecgen`

## Requirements
- R1: After reset, the configuration, mask and flag registers read as zero, `irq_o` is all low, `vec_valid_o` is low and `vec_o` is zero.
- R2: An event pulse sets its flag bit, and the bit reads back set from the cycle after the pulse. The flag bits are: buffer n at bit n (0 to 15), bus-off at bit 16, error at bit 17, wake-up at bit 18.
- R3: A flagged source counts as pending only while its mask bit (same bit position in the mask register) is 1.
- R4: While at least one source is pending and the level field L is not zero, exactly `irq_o[L]` is high and every other line is low. When L is 0, or nothing is pending, no line is high.
- R5: A flag bit clears when a read of the flag register saw it set and a later write to the flag register carries 0 in that bit.
- R6: Writing 1 to a flag bit has no effect. A zero write clears nothing if no read came before it, or if the bit was clear when the last read happened.
- R7: An event on a bit after the arming read, or during the clearing write itself, keeps that bit set after the write.
- R8: On an acknowledge (`iack_i` high) whose level equals a non-zero L, with `arb_win_i` high and a source pending, the next cycle shows `vec_valid_o` high and `vec_o` = {base, code}.
- R9: The source codes are: buffer n gives n, bus-off gives 16, error gives 17, wake-up gives 18. When several sources are pending, the lowest code is returned.
- R10: On a level mismatch, lost arbitration, no pending source, L equal to 0, or no acknowledge, the next cycle shows `vec_valid_o` low and `vec_o` zero.
- R11: Register map (address on `addr_i`). Address 0 is configuration: level L in bits [2:0] and base in bits [10:8]. Address 1 is mask, laid out like the flags. Address 2 is flags. `rdata_o` is zero when `rd_en_i` is low or the address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| buf_evt_i | input | 16 | Per-buffer completion pulses |
| busoff_evt_i | input | 1 | Bus-off event pulse |
| err_evt_i | input | 1 | Error event pulse |
| wake_evt_i | input | 1 | Wake-up event pulse |
| iack_i | input | 1 | Acknowledge cycle active |
| iack_lvl_i | input | 3 | Level being acknowledged |
| arb_win_i | input | 1 | This block won arbitration |
| irq_o | output | 7 | Request lines, index 1 to 7 |
| vec_valid_o | output | 1 | Vector valid |
| vec_o | output | 8 | Interrupt vector |

## Verification
`rdata_o` and `irq_o` have no register between their inputs and the output. They are sampled in the same cycle the stimulus is applied, after the inputs are set up and before the next rising edge, and they reflect the state left by the previous edge. Flag, mask and configuration updates take effect one edge later. The vector is registered, so it is checked shortly after the edge that captured the acknowledge. The bench model advances its state at that same edge, which keeps every expected value aligned to the same cycle as the design.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
  localparam int unsigned NUM_STAT   = 3;
  localparam int unsigned REG_CFG    = 0;
  localparam int unsigned REG_MASK   = 1;
  localparam int unsigned REG_FLAG   = 2;
  localparam int unsigned CFG_LVL_LSB  = 0;
  localparam int unsigned CFG_BASE_LSB = 8;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM_SRC = 19
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               rd_flag_i,
  input  logic               wr_flag_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] flag_o
);
  logic [NUM_SRC-1:0] flag_q, arm_q, clr;

  // only bits seen set by the last read, written 0, with no fresh event
  always_comb clr = wr_flag_i ? (arm_q & ~wdata_i & ~evt_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | evt_i;
      if (wr_flag_i)      arm_q <= '0;
      else if (rd_flag_i) arm_q <= flag_q & ~evt_i;
      else                arm_q <= arm_q & ~evt_i;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_SRC = 19,
  parameter int unsigned CODE_W  = 5
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [CODE_W-1:0]  code_o
);
  always_comb begin
    any_o  = |req_i;
    code_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = CODE_W'(i);
    end
  end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned BASE_W = 3,
  parameter int unsigned CODE_W = 5,
  localparam int unsigned LINES = (1 << LVL_W) - 1,
  localparam int unsigned VEC_W = BASE_W + CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              any_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              iack_i,
  input  logic [LVL_W-1:0]  iack_lvl_i,
  input  logic              arb_win_i,
  output logic [LINES:1]    irq_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic req_on, hit;
  logic vld_q;
  logic [VEC_W-1:0] vec_q;

  assign req_on = any_i && (level_i != '0);
  assign hit    = req_on && iack_i && arb_win_i && (iack_lvl_i == level_i);

  for (genvar g = 1; g <= LINES; g++) begin : g_line
    assign irq_o[g] = req_on && (level_i == LVL_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      vec_q <= '0;
    end else if (hit) begin
      vld_q <= 1'b1;
      vec_q <= {base_i, code_i};
    end else begin
      vld_q <= 1'b0;
      vec_q <= '0;
    end
  end

  assign vec_valid_o = vld_q;
  assign vec_o       = vec_q;
endmodule

// File: rtl/msg_irq_vecgen.sv
module msg_irq_vecgen
  import msg_irq_pkg::*;
#(
  parameter int unsigned NUM_BUF = 16,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned BASE_W  = 3,
  parameter int unsigned CODE_W  = 5,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      rd_en_i,
  input  logic                      wr_en_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [NUM_BUF-1:0]        buf_evt_i,
  input  logic                      busoff_evt_i,
  input  logic                      err_evt_i,
  input  logic                      wake_evt_i,
  input  logic                      iack_i,
  input  logic [LVL_W-1:0]          iack_lvl_i,
  input  logic                      arb_win_i,
  output logic [(1<<LVL_W)-1:1]     irq_o,
  output logic                      vec_valid_o,
  output logic [BASE_W+CODE_W-1:0]  vec_o
);
  localparam int unsigned NUM_SRC = NUM_BUF + NUM_STAT;

  logic sel_cfg, sel_mask, sel_flag;
  logic [LVL_W-1:0]   cfg_lvl_q;
  logic [BASE_W-1:0]  cfg_base_q;
  logic [NUM_SRC-1:0] mask_q, flag_q, evt, pend;
  logic               any_pend;
  logic [CODE_W-1:0]  code;

  assign sel_cfg  = (addr_i == ADDR_W'(REG_CFG));
  assign sel_mask = (addr_i == ADDR_W'(REG_MASK));
  assign sel_flag = (addr_i == ADDR_W'(REG_FLAG));

  // status sources sit above the buffers: bus-off, error, wake-up
  assign evt = {wake_evt_i, err_evt_i, busoff_evt_i, buf_evt_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_lvl_q  <= '0;
      cfg_base_q <= '0;
      mask_q     <= '0;
    end else if (wr_en_i) begin
      if (sel_cfg) begin
        cfg_lvl_q  <= wdata_i[CFG_LVL_LSB +: LVL_W];
        cfg_base_q <= wdata_i[CFG_BASE_LSB +: BASE_W];
      end
      if (sel_mask) mask_q <= wdata_i[NUM_SRC-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (sel_cfg) begin
        rdata_o[CFG_LVL_LSB +: LVL_W]   = cfg_lvl_q;
        rdata_o[CFG_BASE_LSB +: BASE_W] = cfg_base_q;
      end
      if (sel_mask) rdata_o[NUM_SRC-1:0] = mask_q;
      if (sel_flag) rdata_o[NUM_SRC-1:0] = flag_q;
    end
  end

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .rd_flag_i (rd_en_i && sel_flag),
    .wr_flag_i (wr_en_i && sel_flag),
    .wdata_i   (wdata_i[NUM_SRC-1:0]),
    .flag_o    (flag_q)
  );

  assign pend = flag_q & mask_q;

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) i_enc (
    .req_i  (pend),
    .any_o  (any_pend),
    .code_o (code)
  );

  irq_ack_unit #(.LVL_W(LVL_W), .BASE_W(BASE_W), .CODE_W(CODE_W)) i_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_i     (cfg_lvl_q),
    .base_i      (cfg_base_q),
    .any_i       (any_pend),
    .code_i      (code),
    .iack_i      (iack_i),
    .iack_lvl_i  (iack_lvl_i),
    .arb_win_i   (arb_win_i),
    .irq_o       (irq_o),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o)
  );
endmodule

// File: rtl/msg_irq_checker.sv
module msg_irq_checker #(
  parameter int unsigned NUM_SRC = 19,
  parameter int unsigned LVL_W   = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [(1<<LVL_W)-1:1] irq_o,
  input logic                  vec_valid_o,
  input logic                  iack_i,
  input logic                  arb_win_i,
  input logic [LVL_W-1:0]      iack_lvl_i,
  input logic [LVL_W-1:0]      cfg_lvl,
  input logic [NUM_SRC-1:0]    flag_q,
  input logic [NUM_SRC-1:0]    evt,
  input logic                  wr_flag
);
  p_irq_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  p_lvl_zero_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_lvl == '0) |-> (irq_o == '0));

  p_vec_needs_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(iack_i && arb_win_i && (iack_lvl_i == cfg_lvl)));

  p_no_vec_when_lost_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(arb_win_i) |-> !vec_valid_o);

  p_evt_sets_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(evt) & ~flag_q) == '0));

  p_clear_needs_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flag_q) & ~flag_q) != '0) |-> $past(wr_flag));
endmodule

bind msg_irq_vecgen msg_irq_checker #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_o       (irq_o),
  .vec_valid_o (vec_valid_o),
  .iack_i      (iack_i),
  .arb_win_i   (arb_win_i),
  .iack_lvl_i  (iack_lvl_i),
  .cfg_lvl     (cfg_lvl_q),
  .flag_q      (flag_q),
  .evt         (evt),
  .wr_flag     (wr_en_i && sel_flag)
);

// File: tb/test_msg_irq_vecgen.sv
module test_msg_irq_vecgen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        rd_en_i = 1'b0, wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] buf_evt_i = '0;
  logic        busoff_evt_i = 1'b0, err_evt_i = 1'b0, wake_evt_i = 1'b0;
  logic        iack_i = 1'b0;
  logic [2:0]  iack_lvl_i = '0;
  logic        arb_win_i = 1'b0;
  logic [7:1]  irq_o;
  logic        vec_valid_o;
  logic [7:0]  vec_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [2:0]  m_lvl = '0, m_base = '0;
  logic [18:0] m_mask = '0, m_flag = '0, m_arm = '0;

  always #4 clk = ~clk;

  msg_irq_vecgen i_msg_irq_vecgen (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .buf_evt_i(buf_evt_i), .busoff_evt_i(busoff_evt_i), .err_evt_i(err_evt_i),
    .wake_evt_i(wake_evt_i), .iack_i(iack_i), .iack_lvl_i(iack_lvl_i),
    .arb_win_i(arb_win_i), .irq_o(irq_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  function automatic logic [4:0] f_code(input logic [18:0] p);
    for (int i = 0; i < 19; i++) if (p[i]) return 5'(i);
    return 5'd0;
  endfunction

  function automatic logic [7:1] f_irq(input logic [2:0] lvl, input logic [18:0] p);
    if (lvl == 3'd0 || p == '0) return '0;
    return 7'(7'd1 << (lvl - 3'd1));
  endfunction

  function automatic logic [31:0] f_rdata(input logic [1:0] a);
    case (a)
      2'd0: return 32'(m_lvl) | (32'(m_base) << 8);
      2'd1: return 32'(m_mask);
      2'd2: return 32'(m_flag);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [1:0] a, input logic rd, input logic wr,
                      input logic [31:0] wd, input logic [18:0] evt, input logic ack,
                      input logic [2:0] alvl, input logic win);
    logic [18:0] pend, clr, narm;
    logic        hit;
    logic [7:0]  evec;
    @(negedge clk);
    addr_i = a; rd_en_i = rd; wr_en_i = wr; wdata_i = wd;
    buf_evt_i = evt[15:0]; busoff_evt_i = evt[16]; err_evt_i = evt[17]; wake_evt_i = evt[18];
    iack_i = ack; iack_lvl_i = alvl; arb_win_i = win;
    #1;
    pend = m_flag & m_mask;
    if (rd) chk({tag, " rdata"}, rdata_o, f_rdata(a));
    chk({tag, " irq"}, 32'(irq_o), 32'(f_irq(m_lvl, pend)));
    hit  = ack && (alvl == m_lvl) && (m_lvl != 3'd0) && (pend != '0) && win;
    evec = hit ? {m_base, f_code(pend)} : 8'd0;
    clr  = (wr && a == 2'd2) ? (m_arm & ~wd[18:0] & ~evt) : '0;
    if (wr && a == 2'd2)      narm = '0;
    else if (rd && a == 2'd2) narm = m_flag & ~evt;
    else                      narm = m_arm & ~evt;
    @(posedge clk);
    m_flag = (m_flag & ~clr) | evt;
    m_arm  = narm;
    if (wr && a == 2'd0) begin m_lvl = wd[2:0]; m_base = wd[10:8]; end
    if (wr && a == 2'd1) m_mask = wd[18:0];
    #2;
    chk({tag, " vec_valid"}, 32'(vec_valid_o), 32'(hit));
    chk({tag, " vec"}, 32'(vec_o), 32'(evec));
  endtask

  task automatic idle(input string tag);
    step(tag, 2'd3, 1'b0, 1'b0, '0, '0, 1'b0, 3'd0, 1'b0);
  endtask
  task automatic rd(input string tag, input logic [1:0] a);
    step(tag, a, 1'b1, 1'b0, '0, '0, 1'b0, 3'd0, 1'b0);
  endtask
  task automatic wr(input string tag, input logic [1:0] a, input logic [31:0] d);
    step(tag, a, 1'b0, 1'b1, d, '0, 1'b0, 3'd0, 1'b0);
  endtask
  task automatic ev(input string tag, input logic [18:0] e);
    step(tag, 2'd3, 1'b0, 1'b0, '0, e, 1'b0, 3'd0, 1'b0);
  endtask
  task automatic ack(input string tag, input logic [2:0] l, input logic w);
    step(tag, 2'd3, 1'b0, 1'b0, '0, '0, 1'b1, l, w);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1: reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 vec_valid", 32'(vec_valid_o), 0);
    chk("R1 vec", 32'(vec_o), 0);
    rd("R1", 2'd0); rd("R1", 2'd1); rd("R1", 2'd2);
    // R11: register layout
    wr("R11", 2'd0, 32'h0000_0605);
    rd("R11", 2'd0);
    wr("R11", 2'd1, 32'h0007_FF77);
    rd("R11", 2'd1);
    rd("R11", 2'd3);
    // R2 / R3: masked buffer 3 flags but does not request
    ev("R2", 19'h00008);
    rd("R2", 2'd2);
    idle("R3");
    wr("R3", 2'd1, 32'h0007_FFFF);
    idle("R4");
    // R9: lowest code wins among buffers and bus-off
    ev("R2", 19'h10080);
    ack("R9", 3'd5, 1'b1);
    // R10: mismatch, lost arbitration
    ack("R10", 3'd4, 1'b1);
    ack("R10", 3'd5, 1'b0);
    // R6: zero write with no read, one write after read
    wr("R6", 2'd2, 32'h0);
    rd("R6", 2'd2);
    rd("R6", 2'd2);
    wr("R6", 2'd2, 32'hFFFF_FFFF);
    rd("R6", 2'd2);
    // R5: read then zero write clears buffer 3, buffer 7 kept by writing 1
    rd("R5", 2'd2);
    wr("R5", 2'd2, 32'h0000_0080);
    rd("R5", 2'd2);
    ack("R9", 3'd5, 1'b1);
    // R6: bit clear at read time is not cleared by later zero write
    rd("R6", 2'd2);
    ev("R6", 19'h00004);
    wr("R6", 2'd2, 32'h0);
    rd("R6", 2'd2);
    // R7: event between read and write, and during the write
    rd("R7", 2'd2);
    ev("R7", 19'h00004);
    wr("R7", 2'd2, 32'h0);
    rd("R7", 2'd2);
    step("R7", 2'd2, 1'b0, 1'b1, 32'h0, 19'h00004, 1'b0, 3'd0, 1'b0);
    rd("R7", 2'd2);
    // R9: status codes
    rd("R5", 2'd2); wr("R5", 2'd2, 32'h0); rd("R5", 2'd2);
    ev("R2", 19'h60000);
    ack("R9", 3'd5, 1'b1);
    rd("R9", 2'd2); wr("R9", 2'd2, 32'h0004_0000);
    ack("R9", 3'd5, 1'b1);
    // R4 / R10: level zero silences request and acknowledge
    wr("R4", 2'd0, 32'h0000_0300);
    idle("R4");
    ack("R10", 3'd0, 1'b1);
    wr("R4", 2'd0, 32'h0000_0201);
    ack("R8", 3'd1, 1'b1);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [18:0] e;
      int op;
      e = '0;
      for (int b = 0; b < 19; b++) if ($urandom % 40 == 0) e[b] = 1'b1;
      op = $urandom % 100;
      if (op < 25)
        step("R2/R5 rnd", 2'd2, 1'b1, 1'b0, '0, e, 1'b0, 3'd0, 1'b0);
      else if (op < 40)
        step("R6/R7 rnd", 2'd2, 1'b0, 1'b1, ($urandom % 3 == 0) ? $urandom : 32'h0,
             e, 1'b0, 3'd0, 1'b0);
      else if (op < 43)
        step("R11 rnd", 2'd0, 1'b0, 1'b1, $urandom, e, 1'b0, 3'd0, 1'b0);
      else if (op < 46)
        step("R3 rnd", 2'd1, 1'b0, 1'b1, $urandom | 32'h0000_FF00, e, 1'b0, 3'd0, 1'b0);
      else if (op < 70)
        step("R8/R10 rnd", 2'd3, 1'b0, 1'b0, '0, e, 1'b1,
             ($urandom % 4 == 0) ? 3'($urandom) : m_lvl, ($urandom % 10) < 7);
      else
        step("R4 rnd", 2'($urandom), 1'b1, 1'b0, '0, e, 1'b0, 3'd0, 1'b0);
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule